// File: doc/BRIEF.md
# Three-Phase Gate Drive Protection Logic

This block is the digital core that sits between a motor-control processor and the six gate drivers of a three-phase inverter bridge. It takes one high-side and one low-side PWM command per phase, an active-high enable, and a set of fault flags that are already digital. The flags are an overcurrent trip, a main supply undervoltage and one high-side supply undervoltage per phase. It produces six registered gate enables and an active-low fault flag.

All inputs pass through a two-flop synchroniser. The PWM commands then pass through a minimum-pulse filter, so a level change reaches the gates only after it has been held for `FILT_CYC` clocks. A per-phase interlock means a phase never has both of its switches on.

Each protection source recovers in its own way. An overcurrent trip switches the whole bridge off and pulls the fault flag low. The bridge stays off until `CLR_CYC` clocks have passed with the trip inactive, and any new trip during that wait starts the count again. A main supply undervoltage switches the whole bridge off and releases as soon as the supply recovers. A high-side undervoltage switches off only the high-side gate of its own phase. That gate stays off until the supply has recovered and the phase's high command has been seen low.

Top module: `bridge_gate_guard`

## Requirements
- R1: With enable high and no fault, `gate_hi[p]` is 1 exactly when the filtered high command of phase p is 1 and its low command is 0.
- R2: With enable high and no fault, `gate_lo[p]` is 1 exactly when the filtered low command of phase p is 1 and its high command is 0.
- R3: When both commands of a phase are 1, both gate enables of that phase are 0. `gate_hi[p]` and `gate_lo[p]` are never 1 together.
- R4: With `en_in` at 0, all six gate enables are 0 whatever the commands are.
- R5: While `oc_trip` is 1, all six gate enables are 0 and `fault_n` is 0.
- R6: After `oc_trip` returns to 0, `fault_n` stays 0 and the gates stay off for at least `CLR_CYC` clocks. `fault_n` then returns to 1 by itself, within `CLR_CYC`+8 clocks, and the gates follow the commands again.
- R7: A new overcurrent trip during the clear wait restarts the wait from zero.
- R8: `hs_uv[p]` at 1 forces `gate_hi[p]` to 0 and leaves every other gate enable unaffected.
- R9: After `hs_uv[p]` clears, `gate_hi[p]` stays 0 while the high command of phase p remains 1. It follows the commands again only after that command has been seen low, including when the low level arrives in the same cycle as the recovery.
- R10: `main_uv` at 1 forces all six gate enables to 0 and leaves `fault_n` at 1. When it clears, the gates follow the commands again without any command going low.
- R11: A command level held for fewer than `FILT_CYC` clocks is ignored, for both rising (on) pulses and falling (off) pulses. A level held for longer is passed to the gates.
- R12: During reset and right after it, all gate enables are 0 and `fault_n` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hi_in | input | PHASES | High-side PWM command per phase |
| lo_in | input | PHASES | Low-side PWM command per phase |
| en_in | input | 1 | Bridge enable, active high |
| oc_trip | input | 1 | Overcurrent trip flag |
| main_uv | input | 1 | Main supply undervoltage flag |
| hs_uv | input | PHASES | High-side supply undervoltage flag per phase |
| gate_hi | output | PHASES | High-side gate enable per phase |
| gate_lo | output | PHASES | Low-side gate enable per phase |
| fault_n | output | 1 | Overcurrent fault flag, active low |

## Verification
Two recovery events are made to land on the same clock edge. In the first, a phase's high-side supply recovers in the very cycle its high command drops. The bench then raises the command again and expects the high-side gate to follow, because both release conditions held together. In the second, the overcurrent clear wait runs out while the main undervoltage is still active. The bench expects `fault_n` to rise while the gates stay off, and the gates to come back only once the supply flag drops.

// File: rtl/bgg_pkg.sv
package bgg_pkg;

  typedef enum logic [1:0] {
    OC_IDLE = 2'd0,
    OC_TRIP = 2'd1,
    OC_HOLD = 2'd2
  } oc_state_e;

endpackage

// File: rtl/bgg_sync.sv
module bgg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d;
    for (int i = 1; i < STAGES; i++) begin
      stg_d[i] = stg_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) begin
        stg_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < STAGES; i++) begin
        stg_q[i] <= stg_d[i];
      end
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/bgg_pulse_filter.sv
module bgg_pulse_filter #(
  parameter int CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  localparam int FW = $clog2(CYC + 1);

  logic          lvl_q, lvl_d;
  logic [FW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    lvl_d  = lvl_q;
    cnt_d  = '0;
    cnt_en = 1'b1;
    if (din != lvl_q) begin
      if (cnt_q == FW'(CYC - 1)) begin
        lvl_d = din;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (cnt_q == '0) begin
      cnt_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

  assign dout = lvl_q;

endmodule

// File: rtl/bgg_oc_timer.sv
module bgg_oc_timer
  import bgg_pkg::*;
#(
  parameter int CLR_CYC = 1_800_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_s,
  output logic blk,
  output logic fault_n
);

  localparam int CNT_W = $clog2(CLR_CYC);

  oc_state_e      st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic           blk_q;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (oc_s) begin
      st_d  = OC_TRIP;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        OC_TRIP: begin
          st_d  = OC_HOLD;
          cnt_d = '0;
        end
        OC_HOLD: begin
          if (cnt_q == CNT_W'(CLR_CYC - 1)) begin
            st_d  = OC_IDLE;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          st_d  = OC_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= OC_IDLE;
      cnt_q <= '0;
      blk_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      blk_q <= (st_d != OC_IDLE);
    end
  end

  assign blk     = blk_q;
  assign fault_n = ~blk_q;

endmodule

// File: rtl/bgg_phase_gate.sv
module bgg_phase_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic allow,
  input  logic hi_f,
  input  logic lo_f,
  input  logic hs_uv_s,
  output logic g_hi,
  output logic g_lo
);

  logic lock_q, lock_d;
  logic hi_q, hi_d;
  logic lo_q, lo_d;

  always_comb begin
    lock_d = hs_uv_s | (lock_q & hi_f);
    hi_d   = allow & hi_f & ~lo_f & ~hs_uv_s & ~lock_q;
    lo_d   = allow & lo_f & ~hi_f;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      hi_q   <= 1'b0;
      lo_q   <= 1'b0;
    end else begin
      lock_q <= lock_d;
      hi_q   <= hi_d;
      lo_q   <= lo_d;
    end
  end

  assign g_hi = hi_q;
  assign g_lo = lo_q;

endmodule

// File: rtl/bridge_gate_guard.sv
module bridge_gate_guard #(
  parameter int PHASES      = 3,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 4,
  parameter int CLR_CYC     = 1_800_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PHASES-1:0] hi_in,
  input  logic [PHASES-1:0] lo_in,
  input  logic              en_in,
  input  logic              oc_trip,
  input  logic              main_uv,
  input  logic [PHASES-1:0] hs_uv,
  output logic [PHASES-1:0] gate_hi,
  output logic [PHASES-1:0] gate_lo,
  output logic              fault_n
);

  localparam int SW = 3 * PHASES + 3;

  logic [1:0]    rst_sq;
  logic          rst_int_n;
  logic [SW-1:0] raw_vec, syn_vec;
  logic [PHASES-1:0] hi_s, lo_s, hs_uv_s, hi_f, lo_f;
  logic          en_s, oc_s, muv_s;
  logic          blk, allow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sq <= 2'b00;
    end else begin
      rst_sq <= {rst_sq[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sq[1];

  assign raw_vec = {hs_uv, main_uv, en_in, oc_trip, lo_in, hi_in};

  bgg_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (raw_vec),
    .q     (syn_vec)
  );

  assign hi_s    = syn_vec[PHASES-1:0];
  assign lo_s    = syn_vec[2*PHASES-1:PHASES];
  assign oc_s    = syn_vec[2*PHASES];
  assign en_s    = syn_vec[2*PHASES+1];
  assign muv_s   = syn_vec[2*PHASES+2];
  assign hs_uv_s = syn_vec[SW-1:2*PHASES+3];

  bgg_oc_timer #(.CLR_CYC(CLR_CYC)) u_oc (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .oc_s    (oc_s),
    .blk     (blk),
    .fault_n (fault_n)
  );

  assign allow = en_s & ~muv_s & ~blk;

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    bgg_pulse_filter #(.CYC(FILT_CYC)) u_flt_hi (
      .clk   (clk),
      .rst_n (rst_int_n),
      .din   (hi_s[p]),
      .dout  (hi_f[p])
    );
    bgg_pulse_filter #(.CYC(FILT_CYC)) u_flt_lo (
      .clk   (clk),
      .rst_n (rst_int_n),
      .din   (lo_s[p]),
      .dout  (lo_f[p])
    );
    bgg_phase_gate u_gate (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .allow   (allow),
      .hi_f    (hi_f[p]),
      .lo_f    (lo_f[p]),
      .hs_uv_s (hs_uv_s[p]),
      .g_hi    (gate_hi[p]),
      .g_lo    (gate_lo[p])
    );
  end

endmodule

// File: rtl/bgg_checker.sv
module bgg_checker #(
  parameter int PHASES  = 3,
  parameter int CLR_CYC = 1_800_000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_in,
  input logic              oc_trip,
  input logic              main_uv,
  input logic [PHASES-1:0] hs_uv,
  input logic [PHASES-1:0] gate_hi,
  input logic [PHASES-1:0] gate_lo,
  input logic              fault_n
);

  localparam int QW = $clog2(CLR_CYC + 1);

  logic [QW-1:0] quiet_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet_q <= '0;
    end else if (oc_trip) begin
      quiet_q <= '0;
    end else if (quiet_q != QW'(CLR_CYC)) begin
      quiet_q <= quiet_q + 1'b1;
    end
  end

  assert_no_shoot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_hi & gate_lo) == '0);

  assert_enable_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en_in, 3) |-> (gate_hi == '0 && gate_lo == '0));

  assert_fault_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_n && !$past(fault_n)) |-> (gate_hi == '0 && gate_lo == '0));

  assert_clear_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_n) |-> (quiet_q >= QW'(CLR_CYC)));

  assert_main_uv_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(main_uv, 3) |-> (gate_hi == '0 && gate_lo == '0));

  for (genvar p = 0; p < PHASES; p++) begin : g_hs
    assert_hs_uv_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(hs_uv[p], 3) |-> !gate_hi[p]);
  end

endmodule

bind bridge_gate_guard bgg_checker #(.PHASES(PHASES), .CLR_CYC(CLR_CYC)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en_in   (en_in),
  .oc_trip (oc_trip),
  .main_uv (main_uv),
  .hs_uv   (hs_uv),
  .gate_hi (gate_hi),
  .gate_lo (gate_lo),
  .fault_n (fault_n)
);

// File: tb/bridge_gate_guard_test.sv
module bridge_gate_guard_test;

  localparam int PH   = 3;
  localparam int FILT = 4;
  localparam int CLR  = 40;
  localparam int SET  = 14;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [PH-1:0] hi_in, lo_in, hs_uv;
  logic          en_in, oc_trip, main_uv;
  logic [PH-1:0] gate_hi, gate_lo;
  logic          fault_n;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  bridge_gate_guard #(.PHASES(PH), .SYNC_STAGES(2), .FILT_CYC(FILT), .CLR_CYC(CLR)) uut (
    .clk(clk), .rst_n(rst_n), .hi_in(hi_in), .lo_in(lo_in), .en_in(en_in),
    .oc_trip(oc_trip), .main_uv(main_uv), .hs_uv(hs_uv),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .fault_n(fault_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; hi_in = '1; lo_in = '0; hs_uv = '0;
    en_in = 1'b1; oc_trip = 1'b0; main_uv = 1'b0;
    cyc(6);
    // R12: reset state with active commands applied
    chk(gate_hi == 0 && gate_lo == 0, "R12 gates in reset", {gate_hi, gate_lo}, 0);
    chk(fault_n == 1'b1, "R12 fault_n in reset", fault_n, 1);
    hi_in = '0;
    rst_n = 1'b1;
    cyc(1);
    chk(gate_hi == 0 && gate_lo == 0 && fault_n, "R12 after release",
        {fault_n, gate_hi, gate_lo}, 64);
    cyc(SET);

    // R1 R2 R3 R4: exhaustive command sweep
    for (int e = 0; e < 2; e++) begin
      for (int h = 0; h < 8; h++) begin
        for (int l = 0; l < 8; l++) begin
          logic [PH-1:0] eh, el;
          hi_in = PH'(h); lo_in = PH'(l); en_in = e[0];
          cyc(SET);
          eh = e[0] ? (PH'(h) & ~PH'(l)) : '0;
          el = e[0] ? (PH'(l) & ~PH'(h)) : '0;
          if (e == 0) begin
            chk(gate_hi == 0 && gate_lo == 0, "R4", {gate_hi, gate_lo}, 0);
          end else begin
            chk(gate_hi == eh, "R1", gate_hi, eh);
            chk(gate_lo == el, "R2", gate_lo, el);
            if ((h & l) != 0)
              chk(((gate_hi | gate_lo) & PH'(h & l)) == 0, "R3",
                  (gate_hi | gate_lo) & PH'(h & l), 0);
          end
        end
      end
    end

    // R10: main undervoltage, release with commands held high
    en_in = 1'b1; hi_in = 3'b011; lo_in = 3'b100;
    cyc(SET);
    main_uv = 1'b1;
    cyc(SET);
    chk(gate_hi == 0 && gate_lo == 0, "R10 off", {gate_hi, gate_lo}, 0);
    chk(fault_n == 1'b1, "R10 fault_n untouched", fault_n, 1);
    main_uv = 1'b0;
    cyc(SET);
    chk(gate_hi == 3'b011 && gate_lo == 3'b100, "R10 release",
        {gate_hi, gate_lo}, 6'b011100);

    // R8 R9: high-side undervoltage on phase 1
    hi_in = 3'b111; lo_in = 3'b000;
    cyc(SET);
    hs_uv = 3'b010;
    cyc(SET);
    chk(gate_hi == 3'b101, "R8 only phase1 off", gate_hi, 3'b101);
    hs_uv = 3'b000;
    cyc(SET);
    chk(gate_hi == 3'b101, "R9 held while input high", gate_hi, 3'b101);
    hi_in = 3'b101;
    cyc(SET);
    hi_in = 3'b111;
    cyc(SET);
    chk(gate_hi == 3'b111, "R9 release after low", gate_hi, 3'b111);
    // R9: recovery and low command on the same edge
    hs_uv = 3'b001;
    cyc(SET);
    chk(gate_hi == 3'b110, "R8 phase0 off", gate_hi, 3'b110);
    hs_uv = 3'b000; hi_in = 3'b110;
    cyc(SET);
    hi_in = 3'b111;
    cyc(SET);
    chk(gate_hi == 3'b111, "R9 same-cycle release", gate_hi, 3'b111);

    // R5 R6: overcurrent and clear wait
    oc_trip = 1'b1;
    cyc(6);
    chk(fault_n == 1'b0, "R5 fault_n", fault_n, 0);
    chk(gate_hi == 0 && gate_lo == 0, "R5 gates", {gate_hi, gate_lo}, 0);
    oc_trip = 1'b0;
    cyc(CLR - 3);
    chk(fault_n == 1'b0, "R6 still held", fault_n, 0);
    chk(gate_hi == 0, "R6 gates held", gate_hi, 0);
    cyc(11);
    chk(fault_n == 1'b1, "R6 self release", fault_n, 1);
    cyc(4);
    chk(gate_hi == 3'b111, "R6 gates resume", gate_hi, 3'b111);

    // R7: retrip during the wait restarts it
    oc_trip = 1'b1; cyc(3); oc_trip = 1'b0;
    cyc(20);
    oc_trip = 1'b1; cyc(2); oc_trip = 1'b0;
    cyc(CLR - 3);
    chk(fault_n == 1'b0, "R7 restarted wait", fault_n, 0);
    cyc(11);
    chk(fault_n == 1'b1, "R7 release after restart", fault_n, 1);

    // R6 with main undervoltage active at expiry
    oc_trip = 1'b1; cyc(3); oc_trip = 1'b0; main_uv = 1'b1;
    cyc(CLR + 8);
    chk(fault_n == 1'b1, "R6 release under main uv", fault_n, 1);
    chk(gate_hi == 0, "R10 gates still off", gate_hi, 0);
    main_uv = 1'b0;
    cyc(SET);
    chk(gate_hi == 3'b111, "R10 resume after both", gate_hi, 3'b111);

    // R11: short on pulse ignored, short off pulse ignored, long pulse passes
    begin
      bit seen;
      hi_in = 3'b000;
      cyc(SET);
      hi_in = 3'b100; cyc(FILT - 1); hi_in = 3'b000;
      seen = 1'b0;
      for (int i = 0; i < SET; i++) begin
        cyc(1);
        if (gate_hi[2]) seen = 1'b1;
      end
      chk(!seen, "R11 short on pulse", seen, 0);
      hi_in = 3'b111;
      cyc(SET);
      hi_in = 3'b011; cyc(FILT - 1); hi_in = 3'b111;
      seen = 1'b0;
      for (int i = 0; i < SET; i++) begin
        cyc(1);
        if (!gate_hi[2]) seen = 1'b1;
      end
      chk(!seen, "R11 short off pulse", seen, 0);
      hi_in = 3'b011;
      cyc(SET);
      hi_in = 3'b111; cyc(FILT + 4); hi_in = 3'b011;
      seen = 1'b0;
      for (int i = 0; i < SET; i++) begin
        cyc(1);
        if (gate_hi[2]) seen = 1'b1;
      end
      chk(seen, "R11 long pulse passes", seen, 1);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule